// File: doc/BRIEF.md
# Multichannel ADC Frame Reader

This block is a serial master that collects one complete conversion frame from an eight-channel simultaneous-sampling delta-sigma converter each time the converter signals that new data is ready. It watches the active-low data-ready line. On each qualified falling edge it frames a read with chip select and a serial clock derived from the system clock. It then shifts in ten 24-bit words, most significant bit first: a status word, the eight channel samples in ascending channel order, and a trailing check word.

The eight channel samples are sign-extended to 32-bit two's-complement words and appear together on one wide output. A one-cycle valid pulse marks each new frame. Status and check words are clocked in and dropped. Between frames the block goes back to waiting for data-ready, so conversion results stream continuously. A data-ready edge that arrives while a read is in progress is dropped, and a sticky overrun flag is raised. The flag is cleared by reset or by a clear input. The clock divider and the chip-select gaps are parameters counted in system clock cycles.

Top module: `adc_frame_reader`

## Requirements
- R1: While reset is held, chip select is high, the serial clock is low, the valid pulse and overrun flag are low, and every sample lane reads zero.
- R2: A read starts only when data-ready has been seen high and then falls; a data-ready held low from reset onward starts no read.
- R3: Chip select falls at least PRE_CYC cycles after the data-ready fall, the first serial clock rise follows the chip-select fall by at least SETUP_CYC cycles, and the serial clock is low whenever chip select is high.
- R4: The serial clock idles low and gives exactly 240 rising edges per read (ten 24-bit words). The converter changes data on rising edges and the block samples on falling edges, most significant bit first.
- R5: Word order on the wire is status, channel 0 to channel 7, check word; channel k appears on lane k, i.e. samples_o[32k+31:32k].
- R6: Each lane holds its 24-bit sample sign-extended to 32 bits (bits 31:24 copy bit 23).
- R7: The status and check words never appear on any lane.
- R8: Chip select rises no sooner than HOLD_CYC cycles after the last serial clock fall, with no clock edge in between.
- R9: frame_valid_o is high for exactly one cycle per read, and the lanes change only in that cycle and otherwise hold their values.
- R10: After each read the block waits for the next data-ready fall, so back-to-back frames are each read exactly once.
- R11: A data-ready fall while a read is in progress starts no extra read, and it sets overrun_o, which stays set through later clean frames.
- R12: A one-cycle pulse on overrun_clr_i clears overrun_o unless a new overrun occurs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| drdy_n_i | input | 1 | Converter data-ready, active low, asynchronous |
| miso_i | input | 1 | Serial data from converter |
| overrun_clr_i | input | 1 | Clears the overrun flag |
| sclk_o | output | 1 | Generated serial clock, idles low |
| cs_n_o | output | 1 | Chip select, active low |
| samples_o | output | N_CH*OUT_W | Sign-extended samples, lane k at bits 32k+31:32k |
| frame_valid_o | output | 1 | One-cycle pulse when new samples are presented |
| overrun_o | output | 1 | Sticky flag for a data-ready fall during a read |

## Verification
On every cycle, the properties check that the serial clock stays low while chip select is high and that the valid strobe never lasts more than one cycle. They also check that the lanes do not move outside that strobe, that an in-frame data-ready edge raises the overrun flag, and that the flag holds until cleared. The data path itself can only be shown by the scenarios: bit order, channel-to-lane mapping, sign extension at the extreme codes, and that status and check words are dropped. The same holds for the measured chip-select setup and hold gaps, the edge count per frame, the suppressed start when data-ready never went high, and the single read produced from a frame that saw a second data-ready edge.

// File: rtl/adc_frame_pkg.sv
package adc_frame_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_PRE   = 3'd1,
        ST_SETUP = 3'd2,
        ST_SHIFT = 3'd3,
        ST_HOLD  = 3'd4
    } rd_state_e;

endpackage

// File: rtl/adc_drdy_edge.sv
// Synchronises the asynchronous data-ready line and flags a high-to-low
// transition. Register reset value is low, so a line that was never seen
// high cannot produce an edge.
module adc_drdy_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic drdy_n_i,
    output logic fall_o
);

    logic [SYNC_STAGES:0] sync_d, sync_q;

    always_comb begin
        sync_d = {sync_q[SYNC_STAGES-1:0], drdy_n_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= sync_d;
        end
    end

    // oldest stage high, next stage low
    assign fall_o = sync_q[SYNC_STAGES] & ~sync_q[SYNC_STAGES-1];

endmodule

// File: rtl/adc_spi_shifter.sv
// Mode-1 serial engine: clock idles low, data sampled on the falling edge,
// MSB first. Reads N_WORDS words of WORD_W bits after one start pulse.
module adc_spi_shifter #(
    parameter int WORD_W   = 24,
    parameter int N_WORDS  = 10,
    parameter int HALF_DIV = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start_i,
    input  logic                        miso_i,
    output logic                        sclk_o,
    output logic [WORD_W-1:0]           word_o,
    output logic                        strobe_o,
    output logic [$clog2(N_WORDS)-1:0]  widx_o,
    output logic                        done_o
);

    localparam int DIV_W  = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam int BIT_W  = $clog2(WORD_W);
    localparam int WIDX_W = $clog2(N_WORDS);
    localparam logic [DIV_W-1:0]  DIV_LAST  = DIV_W'(HALF_DIV - 1);
    localparam logic [BIT_W-1:0]  BIT_LAST  = BIT_W'(WORD_W - 1);
    localparam logic [WIDX_W-1:0] WORD_LAST = WIDX_W'(N_WORDS - 1);

    typedef struct packed {
        logic              active;
        logic              sclk;
        logic [DIV_W-1:0]  div;
        logic [BIT_W-1:0]  bitc;
        logic [WIDX_W-1:0] wordc;
        logic [WORD_W-1:0] shreg;
        logic              strobe;
        logic [WIDX_W-1:0] widx;
        logic              done;
    } sh_t;

    sh_t sh_d, sh_q;

    always_comb begin
        sh_d        = sh_q;
        sh_d.strobe = 1'b0;
        sh_d.done   = 1'b0;
        if (!sh_q.active) begin
            if (start_i) begin
                sh_d.active = 1'b1;
                sh_d.sclk   = 1'b0;
                sh_d.div    = '0;
                sh_d.bitc   = '0;
                sh_d.wordc  = '0;
            end
        end else if (sh_q.div == DIV_LAST) begin
            sh_d.div  = '0;
            sh_d.sclk = ~sh_q.sclk;
            if (sh_q.sclk) begin
                // falling edge: capture the bit
                sh_d.shreg = {sh_q.shreg[WORD_W-2:0], miso_i};
                if (sh_q.bitc == BIT_LAST) begin
                    sh_d.bitc   = '0;
                    sh_d.strobe = 1'b1;
                    sh_d.widx   = sh_q.wordc;
                    if (sh_q.wordc == WORD_LAST) begin
                        sh_d.active = 1'b0;
                        sh_d.done   = 1'b1;
                        sh_d.wordc  = '0;
                    end else begin
                        sh_d.wordc = sh_q.wordc + 1'b1;
                    end
                end else begin
                    sh_d.bitc = sh_q.bitc + 1'b1;
                end
            end
        end else begin
            sh_d.div = sh_q.div + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign sclk_o   = sh_q.sclk;
    assign word_o   = sh_q.shreg;
    assign strobe_o = sh_q.strobe;
    assign widx_o   = sh_q.widx;
    assign done_o   = sh_q.done;

endmodule

// File: rtl/adc_frame_reader.sv
module adc_frame_reader
    import adc_frame_pkg::*;
#(
    parameter int N_CH        = 8,
    parameter int WORD_W      = 24,
    parameter int OUT_W       = 32,
    parameter int HALF_DIV    = 4,
    parameter int PRE_CYC     = 3,
    parameter int SETUP_CYC   = 3,
    parameter int HOLD_CYC    = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    drdy_n_i,
    input  logic                    miso_i,
    input  logic                    overrun_clr_i,
    output logic                    sclk_o,
    output logic                    cs_n_o,
    output logic [N_CH*OUT_W-1:0]   samples_o,
    output logic                    frame_valid_o,
    output logic                    overrun_o
);

    localparam int N_WORDS = N_CH + 2;   // status + channels + check word
    localparam int WIDX_W  = $clog2(N_WORDS);
    localparam int CH_W    = (N_CH > 1) ? $clog2(N_CH) : 1;
    localparam int GAP_MAX = (PRE_CYC > SETUP_CYC)
                           ? ((PRE_CYC > HOLD_CYC) ? PRE_CYC : HOLD_CYC)
                           : ((SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC);
    localparam int GAP_W   = $clog2(GAP_MAX + 1);
    localparam logic [GAP_W-1:0]  PRE_LAST   = GAP_W'(PRE_CYC - 1);
    localparam logic [GAP_W-1:0]  SETUP_LAST = GAP_W'(SETUP_CYC - 1);
    localparam logic [GAP_W-1:0]  HOLD_LAST  = GAP_W'(HOLD_CYC - 1);
    localparam logic [WIDX_W-1:0] FIRST_CH   = WIDX_W'(1);
    localparam logic [WIDX_W-1:0] LAST_CH    = WIDX_W'(N_CH);

    typedef struct packed {
        rd_state_e                      state;
        logic [GAP_W-1:0]               gap;
        logic                           cs_n;
        logic [N_CH-1:0][WORD_W-1:0]    stage;
        logic [N_CH-1:0][WORD_W-1:0]    held;
        logic                           valid;
        logic                           overrun;
    } rd_t;

    rd_t rd_d, rd_q;

    logic              drdy_fall;
    logic              sh_start;
    logic [WORD_W-1:0] sh_word;
    logic              sh_strobe;
    logic [WIDX_W-1:0] sh_widx;
    logic              sh_done;
    logic [CH_W-1:0]   ch_idx;
    logic              in_frame;

    adc_drdy_edge #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .drdy_n_i (drdy_n_i),
        .fall_o   (drdy_fall)
    );

    adc_spi_shifter #(
        .WORD_W   (WORD_W),
        .N_WORDS  (N_WORDS),
        .HALF_DIV (HALF_DIV)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (sh_start),
        .miso_i   (miso_i),
        .sclk_o   (sclk_o),
        .word_o   (sh_word),
        .strobe_o (sh_strobe),
        .widx_o   (sh_widx),
        .done_o   (sh_done)
    );

    assign ch_idx   = CH_W'(sh_widx - FIRST_CH);
    assign in_frame = (rd_q.state != ST_IDLE);

    always_comb begin
        rd_d       = rd_q;
        rd_d.valid = 1'b0;
        sh_start   = 1'b0;

        unique case (rd_q.state)
            ST_IDLE: begin
                if (drdy_fall) begin
                    rd_d.state = ST_PRE;
                    rd_d.gap   = '0;
                end
            end
            ST_PRE: begin
                if (rd_q.gap == PRE_LAST) begin
                    rd_d.state = ST_SETUP;
                    rd_d.gap   = '0;
                    rd_d.cs_n  = 1'b0;
                end else begin
                    rd_d.gap = rd_q.gap + 1'b1;
                end
            end
            ST_SETUP: begin
                if (rd_q.gap == SETUP_LAST) begin
                    sh_start   = 1'b1;
                    rd_d.state = ST_SHIFT;
                    rd_d.gap   = '0;
                end else begin
                    rd_d.gap = rd_q.gap + 1'b1;
                end
            end
            ST_SHIFT: begin
                if (sh_done) begin
                    rd_d.state = ST_HOLD;
                    rd_d.gap   = '0;
                    rd_d.held  = rd_q.stage;
                    rd_d.valid = 1'b1;
                end
            end
            ST_HOLD: begin
                if (rd_q.gap == HOLD_LAST) begin
                    rd_d.state = ST_IDLE;
                    rd_d.cs_n  = 1'b1;
                end else begin
                    rd_d.gap = rd_q.gap + 1'b1;
                end
            end
            default: begin
                rd_d.state = ST_IDLE;
                rd_d.cs_n  = 1'b1;
            end
        endcase

        // keep channel words only; status and check word are dropped
        if (sh_strobe && sh_widx >= FIRST_CH && sh_widx <= LAST_CH) begin
            rd_d.stage[ch_idx] = sh_word;
        end

        // a new overrun wins over a clear in the same cycle
        if (drdy_fall && in_frame) begin
            rd_d.overrun = 1'b1;
        end else if (overrun_clr_i) begin
            rd_d.overrun = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q      <= '0;
            rd_q.cs_n <= 1'b1;
        end else begin
            rd_q <= rd_d;
        end
    end

    generate
        for (genvar g = 0; g < N_CH; g++) begin : g_lane
            assign samples_o[g*OUT_W +: OUT_W] =
                {{(OUT_W-WORD_W){rd_q.held[g][WORD_W-1]}}, rd_q.held[g]};
        end
    endgenerate

    assign cs_n_o        = rd_q.cs_n;
    assign frame_valid_o = rd_q.valid;
    assign overrun_o     = rd_q.overrun;

endmodule

// File: rtl/adc_frame_reader_chk.sv
module adc_frame_reader_chk #(
    parameter int SAMP_W = 256
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sclk,
    input logic              cs_n,
    input logic              frame_valid,
    input logic [SAMP_W-1:0] samples,
    input logic              overrun,
    input logic              overrun_clr,
    input logic              drdy_fall,
    input logic              in_frame
);

    assert_sclk_low_deselected_R3: assert property (
        @(posedge clk) disable iff (!rst_n) cs_n |-> !sclk);

    assert_valid_one_cycle_R9: assert property (
        @(posedge clk) disable iff (!rst_n) frame_valid |=> !frame_valid);

    assert_samples_held_R9: assert property (
        @(posedge clk) disable iff (!rst_n) !frame_valid |-> $stable(samples));

    assert_overrun_set_R11: assert property (
        @(posedge clk) disable iff (!rst_n) (drdy_fall && in_frame) |=> overrun);

    assert_overrun_sticky_R11: assert property (
        @(posedge clk) disable iff (!rst_n) (overrun && !overrun_clr) |=> overrun);

    assert_overrun_clear_R12: assert property (
        @(posedge clk) disable iff (!rst_n)
        (overrun_clr && !(drdy_fall && in_frame)) |=> !overrun);

endmodule

bind adc_frame_reader adc_frame_reader_chk #(
    .SAMP_W (N_CH*OUT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sclk        (sclk_o),
    .cs_n        (cs_n_o),
    .frame_valid (frame_valid_o),
    .samples     (samples_o),
    .overrun     (overrun_o),
    .overrun_clr (overrun_clr_i),
    .drdy_fall   (drdy_fall),
    .in_frame    (in_frame)
);

// File: tb/adc_frame_reader_tb.sv
`timescale 1ns/1ps
module adc_frame_reader_tb;

    localparam int N_CH      = 8;
    localparam int WORD_W    = 24;
    localparam int OUT_W     = 32;
    localparam int HALF_DIV  = 4;
    localparam int PRE_CYC   = 3;
    localparam int SETUP_CYC = 3;
    localparam int HOLD_CYC  = 3;
    localparam int TOT_BITS  = (N_CH + 2) * WORD_W;
    localparam int SW        = N_CH * OUT_W;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          drdy_n = 1'b0;
    logic          miso = 1'b0;
    logic          ovr_clr = 1'b0;
    logic          sclk, cs_n, frame_valid, overrun;
    logic [SW-1:0] samples;

    always #2 clk = ~clk;  // 250 MHz

    adc_frame_reader #(
        .N_CH(N_CH), .WORD_W(WORD_W), .OUT_W(OUT_W), .HALF_DIV(HALF_DIV),
        .PRE_CYC(PRE_CYC), .SETUP_CYC(SETUP_CYC), .HOLD_CYC(HOLD_CYC)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .drdy_n_i(drdy_n), .miso_i(miso),
        .overrun_clr_i(ovr_clr), .sclk_o(sclk), .cs_n_o(cs_n),
        .samples_o(samples), .frame_valid_o(frame_valid), .overrun_o(overrun)
    );

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // ---------------- converter model: changes data on rising edge ----
    logic [TOT_BITS-1:0] frame_bits = '0;
    int bit_idx = 0;
    always @(posedge sclk or negedge cs_n) begin
        if (sclk) begin
            miso = (bit_idx < TOT_BITS) ? frame_bits[TOT_BITS-1-bit_idx] : 1'b0;
            bit_idx++;
        end else begin
            bit_idx = 0;
            miso = 1'b0;
        end
    end

    // ---------------- scoreboard ----------------
    logic [SW-1:0] exp_q[$];
    logic [SW-1:0] rej_q[$];  // sign-extended status/check words per frame
    int frames_seen = 0;
    int cs_falls = 0;

    function automatic logic [31:0] sext(input logic [23:0] w);
        return {{8{w[23]}}, w};
    endfunction

    // monitor, sampled on the falling clock edge
    logic          p_cs = 1'b1, p_sclk = 1'b0, p_valid = 1'b0, first_rise = 1'b0;
    logic          moved = 1'b0, desel_hi = 1'b0;
    logic [SW-1:0] p_samp = '0;
    int            since_cs = 0, since_fall = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            since_cs++;
            since_fall++;
            if (cs_n && sclk) desel_hi = 1'b1;
            if (p_cs && !cs_n) begin
                cs_falls++;
                since_cs   = 0;
                first_rise = 1'b1;
            end
            if (!p_sclk && sclk && first_rise) begin
                first_rise = 1'b0;
                check(since_cs >= SETUP_CYC, "R3 setup gap", since_cs, SETUP_CYC);
            end
            if (p_sclk && !sclk) since_fall = 0;
            if (!p_cs && cs_n) begin
                check(since_fall >= HOLD_CYC, "R8 hold gap", since_fall, HOLD_CYC);
                check(bit_idx == TOT_BITS, "R4 rising edges per frame", bit_idx, TOT_BITS);
                check(!desel_hi, "R3 sclk high while deselected", desel_hi, 0);
            end
            if (p_valid) check(!frame_valid, "R9 valid width", frame_valid, 0);
            if (!frame_valid && samples != p_samp) moved = 1'b1;
            if (frame_valid) begin
                frames_seen++;
                check(!moved, "R9 lanes held between frames", moved, 0);
                moved = 1'b0;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R10 unexpected frame", 1, 0);
                end else begin
                    logic [SW-1:0] e, r;
                    e = exp_q.pop_front();
                    r = rej_q.pop_front();
                    for (int k = 0; k < N_CH; k++) begin
                        check(samples[k*32 +: 32] == e[k*32 +: 32],
                              $sformatf("R5 R6 lane %0d", k),
                              samples[k*32 +: 32], e[k*32 +: 32]);
                        check(samples[k*32 +: 32] != r[31:0] &&
                              samples[k*32 +: 32] != r[63:32],
                              $sformatf("R7 lane %0d carries status/check", k),
                              samples[k*32 +: 32], r[63:0]);
                    end
                end
            end
            p_cs = cs_n; p_sclk = sclk; p_valid = frame_valid; p_samp = samples;
        end
    end

    // ---------------- driver ----------------
    task automatic run_frame(input logic [23:0] st, input logic [N_CH-1:0][23:0] ch,
                             input logic [23:0] crc, input bit extra_edge);
        logic [SW-1:0] e;
        int f0;
        frame_bits[TOT_BITS-1 -: 24] = st;
        for (int k = 0; k < N_CH; k++) begin
            frame_bits[TOT_BITS-1-24*(k+1) -: 24] = ch[k];
            e[k*32 +: 32] = sext(ch[k]);
        end
        frame_bits[23:0] = crc;
        exp_q.push_back(e);
        rej_q.push_back({{(SW-64){1'b0}}, sext(crc), sext(st)});
        f0 = frames_seen;
        @(negedge clk) drdy_n = 1'b0;
        repeat (8) @(negedge clk);
        drdy_n = 1'b1;
        if (extra_edge) begin
            repeat (400) @(negedge clk);
            drdy_n = 1'b0;
            repeat (8) @(negedge clk);
            drdy_n = 1'b1;
        end
        while (frames_seen == f0) @(negedge clk);
        repeat (20) @(negedge clk);
    endtask

    function automatic logic [N_CH-1:0][23:0] mk(input logic [23:0] base,
                                                 input logic [23:0] step);
        logic [N_CH-1:0][23:0] r;
        for (int k = 0; k < N_CH; k++) r[k] = base + step * 24'(k);
        return r;
    endfunction

    initial begin
        int falls0;
        logic [N_CH-1:0][23:0] c;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(cs_n == 1'b1, "R1 cs_n", cs_n, 1);
        check(sclk == 1'b0, "R1 sclk", sclk, 0);
        check(frame_valid == 1'b0, "R1 valid", frame_valid, 0);
        check(samples == '0, "R1 samples", samples[63:0], 0);
        check(overrun == 1'b0, "R1 overrun", overrun, 0);
        rst_n = 1'b1;
        // R2: drdy held low from reset never starts a read
        repeat (100) @(negedge clk);
        check(cs_falls == 0, "R2 no start without high", cs_falls, 0);
        check(cs_n == 1'b1, "R2 cs_n idle", cs_n, 1);
        drdy_n = 1'b1;
        repeat (10) @(negedge clk);

        // ascending positive pattern
        run_frame(24'h0A0B0C, mk(24'h012345, 24'h111111), 24'h00C3C3, 1'b0);
        // extreme codes
        c = '0;
        c[0] = 24'h800000; c[1] = 24'h7FFFFF; c[2] = 24'h000000; c[3] = 24'hFFFFFF;
        c[4] = 24'h800001; c[5] = 24'h000001; c[6] = 24'hA5A5A5; c[7] = 24'h5A5A5A;
        run_frame(24'h7FFFFE, c, 24'h800002, 1'b0);
        // negative descending, back-to-back
        run_frame(24'h123123, mk(24'hF00000, 24'hFF0101), 24'h321321, 1'b0);
        check(overrun == 1'b0, "R11 no overrun on clean frames", overrun, 0);

        // R11: second drdy edge mid-frame
        falls0 = cs_falls;
        run_frame(24'h00AA55, mk(24'h400000, 24'h0F0F0F), 24'h00BEEF, 1'b1);
        repeat (300) @(negedge clk);
        check(overrun == 1'b1, "R11 overrun set", overrun, 1);
        check(cs_falls == falls0 + 1, "R11 extra edge ignored", cs_falls, falls0 + 1);
        check(exp_q.size() == 0, "R11 no extra frame", exp_q.size(), 0);
        run_frame(24'h000111, mk(24'hC00000, 24'h050505), 24'h000222, 1'b0);
        check(overrun == 1'b1, "R11 overrun sticky", overrun, 1);

        // R12 clear
        @(negedge clk) ovr_clr = 1'b1;
        @(negedge clk) ovr_clr = 1'b0;
        check(overrun == 1'b0, "R12 overrun cleared", overrun, 0);
        run_frame(24'h0FEDCB, mk(24'h7FFFF0, 24'h000003), 24'h0ABCDE, 1'b0);
        check(frames_seen == 6, "R10 every frame read once", frames_seen, 6);

        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog act=hung exp=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
            $finish;
        end
    end

endmodule